// File: doc/BRIEF.md
# Periodic Wakeup Interrupt Timer

This block raises a timeout flag at a fixed, software-chosen interval. Software programs a 16-bit rate value N through two byte-wide registers on a simple register bus. It then sets an enable bit. The timer counts 2*(N+1) ticks of a selectable timebase and sets a flag at the end of each period. The flag stays set until software writes one to it. When the interrupt-enable bit is also set, the flag drives an interrupt output.

The timebase is either the bus clock itself or a slow free-running clock. The slow clock is never used as a clock. It is sampled into the bus domain through a synchroniser and an edge detector. Each detected rising edge is one slow cycle. A divide-by-two then makes one tick out of every two slow cycles. After each enable, a synchronous gate lets the slow ticks through only once a short warm-up has passed. This warm-up makes the first slow-clock period two to three slow cycles longer than the following ones.

The rate value and the clock-select bit are locked while the timer runs, so the period can only be changed while the timer is stopped. Clearing the enable bit stops the counter and sets it back to zero.

Top module: `pwit_top`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: The rate value N is held in two registers. Address 2 holds bits 15:8 and address 3 holds bits 7:0. Both can be read back at any time, including while the timer runs.
- R3: The control register is at address 0, with bit 0 = enable, bit 1 = clock select and bit 2 = interrupt enable. While enable is set, writes to addresses 2 and 3 and to the clock-select bit are ignored.
- R4: With clock select = 1, the flag first becomes visible 2*(N+1) bus cycles after the clock edge that wrote enable = 1. After that it sets again every 2*(N+1) bus cycles.
- R5: With clock select = 0, once running, the flag sets every 2*(N+1)*2 slow-clock periods.
- R6: With clock select = 0, the first timeout after enabling comes later than the steady-state period by between two and three slow-clock periods.
- R7: The flag is bit 0 at address 1. Writing one clears it and writing zero has no effect. If a timeout and a clearing write fall in the same cycle, the flag stays set.
- R8: `irq_o` is high exactly when the flag is set and interrupt enable is set.
- R9: Clearing enable resets the period count, so the next enable starts a fresh, full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_clk | input | 1 | Free-running slow clock, asynchronous to `clk` |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
A timeout and a write-one-to-clear of the flag can land on the same clock edge. The bench provokes this with the bus clock as timebase. It counts cycles from the enabling write, so that the clearing write reaches the register in exactly the cycle in which the count wraps. The result is judged at the interrupt output, which must still be high after that edge. A later normal clear must then bring it low. A second overlap case writes new rate values and a new clock select in the middle of a running period. Read-back and the timing of the next timeout must show that those writes were ignored.

// File: rtl/pwit_pkg.sv
// Package: shared constants for the periodic wakeup interrupt timer.
// Assumes a byte-wide register bus with a two-bit address.
package pwit_pkg;
    localparam int RATE_W = 16;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_RATE_H = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_RATE_L = 2'd3;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_SEL_BIT = 1;
    localparam int CTRL_IE_BIT  = 2;
    localparam int STAT_FLG_BIT = 0;
endpackage

// File: rtl/pwit_regs.sv
// Register file: control, status flag and the two rate bytes.
// Rate bytes and the clock-select bit accept writes only while the
// timer is stopped. The flag is write-one-to-clear, and a timeout
// event in the same cycle takes priority over the clear.
module pwit_regs
    import pwit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              flag_evt,
    output logic              en_o,
    output logic              sel_o,
    output logic              ie_o,
    output logic [RATE_W-1:0] rate_o,
    output logic              flag_o
);
    localparam int HALF = RATE_W / 2;

    logic wr_stb;
    assign wr_stb = bus_sel && bus_wr;

    // Control bits; clock select is protected while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o  <= 1'b0;
            sel_o <= 1'b0;
            ie_o  <= 1'b0;
        end else if (wr_stb && bus_addr == ADDR_CTRL) begin
            en_o <= bus_wdata[CTRL_EN_BIT];
            ie_o <= bus_wdata[CTRL_IE_BIT];
            if (!en_o) begin
                sel_o <= bus_wdata[CTRL_SEL_BIT];
            end
        end
    end

    // Rate bytes; writes land only while the timer is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_o <= '0;
        end else if (wr_stb && !en_o) begin
            if (bus_addr == ADDR_RATE_H) begin
                rate_o[RATE_W-1:HALF] <= bus_wdata;
            end else if (bus_addr == ADDR_RATE_L) begin
                rate_o[HALF-1:0] <= bus_wdata;
            end
        end
    end

    // Timeout flag: set by event, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (flag_evt) begin
            flag_o <= 1'b1;
        end else if (wr_stb && bus_addr == ADDR_STAT && bus_wdata[STAT_FLG_BIT]) begin
            flag_o <= 1'b0;
        end
    end

    // Read multiplexer, always available.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CTRL_EN_BIT]  = en_o;
                bus_rdata[CTRL_SEL_BIT] = sel_o;
                bus_rdata[CTRL_IE_BIT]  = ie_o;
            end
            ADDR_STAT:   bus_rdata[STAT_FLG_BIT] = flag_o;
            ADDR_RATE_H: bus_rdata = rate_o[RATE_W-1:HALF];
            default:     bus_rdata = rate_o[HALF-1:0];
        endcase
    end
endmodule

// File: rtl/pwit_tbase.sv
// Timebase: turns either the bus clock or a slow asynchronous clock
// into single-cycle ticks. The slow clock passes through a
// SYNC_STAGES synchroniser and a rising-edge detector. A warm-up gate
// swallows the first WARMUP slow edges after each enable, and a
// divide-by-two then yields one tick per two slow cycles.
// Assumes the slow clock is much slower than the bus clock.
module pwit_tbase #(
    parameter int SYNC_STAGES = 2,
    parameter int WARMUP      = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_clk,
    input  logic en,
    input  logic sel_bus,
    output logic tick
);
    localparam int GW = $clog2(WARMUP + 1);
    localparam logic [GW-1:0] GATE_LAST = GW'(WARMUP);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   rise;
    logic [GW-1:0]          gate_q;
    logic                   gate_open;
    logic                   half_q;
    logic                   slow_tick;

    // Synchroniser chain for the slow clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], slow_clk};
        end
    end

    // Delayed copy for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise      = sync_q[SYNC_STAGES-1] && !last_q;
    assign gate_open = (gate_q == GATE_LAST);

    // Warm-up gate counting slow edges after enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            gate_q <= '0;
        end else if (rise && !gate_open) begin
            gate_q <= gate_q + 1'b1;
        end
    end

    // Divide-by-two of the gated slow edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            half_q <= 1'b0;
        end else if (rise && gate_open) begin
            half_q <= !half_q;
        end
    end

    assign slow_tick = rise && gate_open && half_q;

    // Timebase selection.
    always_comb begin
        tick = sel_bus ? 1'b1 : slow_tick;
    end
endmodule

// File: rtl/pwit_counter.sv
// Period counter: counts ticks from 0 to 2*N+1 and emits a one-cycle
// event on the wrapping tick. Held at zero while disabled.
// Assumes the rate is stable while enabled.
module pwit_counter #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    output logic [RATE_W:0]   cnt_o,
    output logic              evt_o
);
    logic [RATE_W:0] limit;
    logic            at_limit;

    assign limit    = {rate, 1'b1};
    assign at_limit = (cnt_o == limit);

    // Tick counter with wrap at the programmed limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_o <= '0;
        end else if (tick) begin
            cnt_o <= at_limit ? '0 : cnt_o + 1'b1;
        end
    end

    assign evt_o = en && tick && at_limit;
endmodule

// File: rtl/pwit_top.sv
// Top of the periodic wakeup interrupt timer: register file, timebase
// and period counter. The interrupt is the flag gated by its enable.
module pwit_top
    import pwit_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WARMUP      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_o
);
    logic              en_q;
    logic              sel_q;
    logic              ie_q;
    logic [RATE_W-1:0] rate_q;
    logic              flag_q;
    logic              flag_evt;
    logic              tick;
    logic [RATE_W:0]   cnt_q;

    pwit_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .flag_evt  (flag_evt),
        .en_o      (en_q),
        .sel_o     (sel_q),
        .ie_o      (ie_q),
        .rate_o    (rate_q),
        .flag_o    (flag_q)
    );

    pwit_tbase #(
        .SYNC_STAGES (SYNC_STAGES),
        .WARMUP      (WARMUP)
    ) u_tbase (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_clk (slow_clk),
        .en       (en_q),
        .sel_bus  (sel_q),
        .tick     (tick)
    );

    pwit_counter #(
        .RATE_W (RATE_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_q),
        .tick  (tick),
        .rate  (rate_q),
        .cnt_o (cnt_q),
        .evt_o (flag_evt)
    );

    // Interrupt request from flag and its enable.
    always_comb begin
        irq_o = flag_q && ie_q;
    end
endmodule

// File: rtl/pwit_checker.sv
// Checker for pwit_top: locking, flag causality and counter bounds.
module pwit_checker #(
    parameter int RW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [1:0]    bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          en_q,
    input logic          sel_q,
    input logic [RW-1:0] rate_q,
    input logic          flag_q,
    input logic          flag_evt,
    input logic [RW:0]   cnt_q
);
    a_r3_rate_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_q) |-> $stable(rate_q));

    a_r3_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_q) |-> $stable(sel_q));

    a_r7_set_by_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(flag_evt));

    a_r7_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(bus_sel && bus_wr && bus_addr == 2'd1 && bus_wdata[0] && !flag_evt));

    a_r9_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en_q) |-> (cnt_q == '0));

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> (cnt_q <= {rate_q, 1'b1}));

    a_r4_evt_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        flag_evt |-> en_q);
endmodule

bind pwit_top pwit_checker #(.RW(16)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en_q      (en_q),
    .sel_q     (sel_q),
    .rate_q    (rate_q),
    .flag_q    (flag_q),
    .flag_evt  (flag_evt),
    .cnt_q     (cnt_q)
);

// File: tb/pwit_top_tb_top.sv
// Bench for pwit_top: directed corners plus seeded random rates.
// The slow clock has a period of eight bus cycles.
module pwit_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_clk = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_o;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int sdiv = 0;
    int nsets = 0;
    int last_set = 0;
    int prev_set = 0;
    logic irq_d = 1'b0;
    bit done = 0;

    pwit_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_clk  (slow_clk),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Slow clock: toggles every four bus cycles.
    always @(negedge clk) begin
        sdiv = sdiv + 1;
        if (sdiv == 4) begin
            sdiv = 0;
            slow_clk = ~slow_clk;
        end
    end

    // Record the cycle of every rising interrupt.
    always @(negedge clk) begin
        if (irq_o && !irq_d) begin
            prev_set = last_set;
            last_set = cyc;
            nsets++;
        end
        irq_d = irq_o;
    end

    function automatic int exp_fast(int n);
        return 2 * (n + 1);
    endfunction

    function automatic int exp_slow(int n);
        return 2 * (n + 1) * 2 * 8;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_rate(int n);
        wr(2'd2, n[15:8]);
        wr(2'd3, n[7:0]);
    endtask

    task automatic stop_all();
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h01);
    endtask

    task automatic wait_set(int k);
        for (int t = 0; t < 6000 && nsets < k; t++) @(negedge clk);
    endtask

    // Bus-clock timebase: first period and steady spacing (R4).
    task automatic run_fast(int n);
        int k;
        int en_cyc;
        stop_all();
        set_rate(n);
        k = nsets;
        wr(2'd0, 8'h07);
        en_cyc = cyc;
        wait_set(k + 1);
        check(nsets == k + 1 && last_set - en_cyc == exp_fast(n), "R4 first",
              last_set - en_cyc, exp_fast(n));
        wr(2'd1, 8'h01);
        wait_set(k + 2);
        check(last_set - prev_set == exp_fast(n), "R4 spacing",
              last_set - prev_set, exp_fast(n));
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] h;
        int k;
        int en_cyc;
        int n;
        int d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check(v == 8'h00, "R1 reg", v, 0);
        end
        check(irq_o == 1'b0, "R1 irq", irq_o, 0);

        // R2: byte placement and read-back while stopped
        set_rate(16'h1A2B);
        rd(2'd2, v); check(v == 8'h1A, "R2 high", v, 8'h1A);
        rd(2'd3, v); check(v == 8'h2B, "R2 low", v, 8'h2B);

        // R4: directed small rates
        run_fast(2);
        run_fast(7);

        // R7: writing zero leaves flag set; R8: irq follows ie
        wr(2'd1, 8'h00);
        check(irq_o == 1'b1, "R7 write zero", irq_o, 1);
        wr(2'd0, 8'h03);
        rd(2'd1, v);
        check(irq_o == 1'b0 && v[0] == 1'b1, "R8 ie off", irq_o, 0);
        wr(2'd0, 8'h07);
        check(irq_o == 1'b1, "R8 ie on", irq_o, 1);

        // R3: locked rate and select while running; R2 read-back while enabled
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hEE);
        wr(2'd0, 8'h05);
        rd(2'd2, h); rd(2'd3, v);
        check({h, v} == 16'd7, "R3 rate locked", {h, v}, 7);
        rd(2'd0, v);
        check(v == 8'h07, "R3 select locked", v, 7);

        // R7: timeout and clear in the same cycle; set wins
        stop_all();
        set_rate(5);
        wr(2'd0, 8'h07);
        repeat (10) @(negedge clk);
        wr(2'd1, 8'h01);
        check(irq_o == 1'b1, "R7 set beats clear", irq_o, 1);
        wr(2'd1, 8'h01);
        check(irq_o == 1'b0, "R7 clear", irq_o, 0);

        // R9: disable mid-period, re-enable gives a full period
        stop_all();
        wr(2'd0, 8'h07);
        repeat (5) @(negedge clk);
        wr(2'd0, 8'h06);
        repeat (3) @(negedge clk);
        k = nsets;
        wr(2'd0, 8'h07);
        en_cyc = cyc;
        wait_set(k + 1);
        check(last_set - en_cyc == exp_fast(5), "R9 fresh period",
              last_set - en_cyc, exp_fast(5));

        // R6 and R5: slow timebase
        stop_all();
        set_rate(2);
        k = nsets;
        wr(2'd0, 8'h05);
        en_cyc = cyc;
        wait_set(k + 1);
        d = last_set - en_cyc - exp_slow(2);
        check(nsets == k + 1 && d >= 16 && d <= 26, "R6 first extra", d, 20);
        wr(2'd1, 8'h01);
        wait_set(k + 2);
        check(last_set - prev_set == exp_slow(2), "R5 spacing",
              last_set - prev_set, exp_slow(2));

        // Random rates on the bus timebase, with locked writes mixed in
        for (int i = 0; i < 6; i++) begin
            n = $urandom_range(40, 2);
            run_fast(n);
            wr(2'd3, 8'($urandom_range(255, 0)));
            rd(2'd2, h); rd(2'd3, v);
            check({h, v} == 16'(n), "R3 random locked", {h, v}, n);
        end

        stop_all();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end
endmodule